// File: doc/BRIEF.md
# Timer with Coherent Byte Readout

This block is a 16-bit up-counter with two capture channels and two compare channels. Its register bus is only 8 bits wide, so a processor needs two reads to fetch any 16-bit value. To make those two reads return bytes that belong to the same instant, a read of a low byte also copies the matching high byte into a shadow register. The later high-byte read returns that shadow copy and not the live bits. Software therefore gets a coherent value without a retry loop, and the counter does not have to be frozen.

The counter counts either the system clock or the rising edges of an external clock pin. The external pin passes through a two-flop synchronizer first. Rising edges on two capture pins copy the live count into capture registers. The count pair and both capture pairs use the shadow mechanism described above. Each compare output pulses for one cycle when the count reaches its programmed 16-bit value.

Top module: `tmr_coherent_top`

## Requirements
- R1: After reset, the count, both captures, both compares and the control register are zero, and so is the shadow. Both compare outputs are low. A read of any address, including an unused one, returns 0.
- R2: A read of a low-byte address returns the live low byte of its pair. In the same clock it copies that pair's high byte into one shadow register shared by all pairs. The low-byte addresses are 0x0 for the count, 0x2 for capture A and 0x4 for capture B.
- R3: A read of a high-byte address returns the shadow register and not the live high byte. The high-byte addresses are 0x1 for the count, 0x3 for capture A and 0x5 for capture B.
- R4: A high-byte read that comes without a preceding low-byte read of the same pair returns the stale shadow. That is the high byte latched by the most recent low-byte read of any pair.
- R5: Both capture pairs return their full 16-bit captured value through a read of the low byte followed by a read of the high byte.
- R6: The control register is at address 0xA. Bit 0 enables counting and bit 1 selects the source (0 = system clock, 1 = external pin). When running from the system clock, the count rises by one on every clock. It wraps from 0xFFFF to 0x0000.
- R7: When running from the external source, the count rises by one for each rising edge of `ext_clk`, after a two-flop synchronizer. It does not change while that pin is idle.
- R8: A rising edge on `cap_a_in` or `cap_b_in` copies the live count into capture A or capture B. A pin that stays high, or that falls, leaves the capture unchanged.
- R9: Compare A is at 0x6 (low byte) and 0x7 (high byte) and drives `cmp_a_out`. Compare B is at 0x8 and 0x9 and drives `cmp_b_out`. An output is high for one cycle, in the first cycle that the count register holds a newly loaded value equal to the compare value.
- R10: A write to a compare low byte is only staged. The new 16-bit compare value takes effect on the write of the high byte. Reads of compare addresses return the bytes of the value in effect.
- R11: A write to count address 0x0 or 0x1 loads that byte at the next clock edge and leaves the other byte unchanged. In that cycle the write takes precedence over counting.
- R12: Reads never stop or stall the counter. The count keeps advancing between the low-byte read and the high-byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External count clock, asynchronous |
| cap_a_in | input | 1 | Capture A trigger, asynchronous |
| cap_b_in | input | 1 | Capture B trigger, asynchronous |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current address |
| cmp_a_out | output | 1 | Compare A match pulse |
| cmp_b_out | output | 1 | Compare B match pulse |

## Verification
The assertions assume several things about the inputs:
- `rd_en` and `wr_en` are never high in the same cycle.
- Each strobe lasts exactly one clock.
- The asynchronous pins change slowly enough for every edge to survive the two-flop synchronizer.

The stimulus meets these assumptions. It drives each strobe from a task that raises it for a single cycle on the falling clock edge. It holds `ext_clk` and the capture pins at each level for at least three system clocks. It changes the count only while counting is disabled, or while the source is the external pin, so that the expected values depend on nothing but the number of elapsed clocks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO  = 4'h0,
    A_CNT_HI  = 4'h1,
    A_CAPA_LO = 4'h2,
    A_CAPA_HI = 4'h3,
    A_CAPB_LO = 4'h4,
    A_CAPB_HI = 4'h5,
    A_CMPA_LO = 4'h6,
    A_CMPA_HI = 4'h7,
    A_CMPB_LO = 4'h8,
    A_CMPB_HI = 4'h9,
    A_CTRL    = 4'hA
  } tmr_addr_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // sr[STAGES-1:0] is the synchronizer chain; sr[STAGES] holds the previous level
  logic [STAGES:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rise = sr_q[STAGES-1] & ~sr_q[STAGES];

  // R7 / R8: a detected edge lasts exactly one cycle
  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_d,
  output logic              cnt_load
);
  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_d[DATA_W-1:0]     = wdata;
      if (wr_hi) cnt_d[CNT_W-1:DATA_W] = wdata;
    end else if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    cnt_load = wr_lo | wr_hi | tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_load) cnt_q <= cnt_d;
  end

  // R6: increment by one with wrap when ticking and not written
  a_r6_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_lo && !wr_hi) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R11: a low-byte write lands on the next edge
  a_r11_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_q[DATA_W-1:0] == $past(wdata));

  // R11: a high-byte write leaves the low byte alone
  a_r11_hi_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> cnt_q[DATA_W-1:0] == $past(cnt_q[DATA_W-1:0]));
endmodule

// File: rtl/tmr_regbus.sv
module tmr_regbus
  import tmr_pkg::*;
#(
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned CNT_W  = 2 * DATA_W,
  localparam int unsigned NCH    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rd_en,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rd_data,
  input  logic [CNT_W-1:0]          cnt_q,
  input  logic [CNT_W-1:0]          cnt_d,
  input  logic                      cnt_load,
  input  logic [NCH-1:0][CNT_W-1:0] cap_q,
  output logic                      run,
  output logic                      ext_sel,
  output logic                      cnt_wr_lo,
  output logic                      cnt_wr_hi,
  output logic [NCH-1:0]            cmp_pulse
);
  tmr_addr_e sel;
  assign sel = tmr_addr_e'(addr);

  logic [DATA_W-1:0]         shadow_q, shadow_d;
  logic                      shadow_en;
  logic [NCH-1:0][CNT_W-1:0] cmp_q, cmp_d;
  logic [NCH-1:0][DATA_W-1:0] stage_q, stage_d;
  logic [NCH-1:0]            pulse_q, pulse_d;
  logic                      run_q, ext_q, ctrl_we;

  assign ctrl_we   = wr_en && (sel == A_CTRL);
  assign cnt_wr_lo = wr_en && (sel == A_CNT_LO);
  assign cnt_wr_hi = wr_en && (sel == A_CNT_HI);

  // Low-byte read of any pair latches that pair's high byte
  always_comb begin
    shadow_en = 1'b0;
    shadow_d  = shadow_q;
    if (rd_en) begin
      case (sel)
        A_CNT_LO:  begin shadow_en = 1'b1; shadow_d = cnt_q[CNT_W-1:DATA_W];    end
        A_CAPA_LO: begin shadow_en = 1'b1; shadow_d = cap_q[0][CNT_W-1:DATA_W]; end
        A_CAPB_LO: begin shadow_en = 1'b1; shadow_d = cap_q[1][CNT_W-1:DATA_W]; end
        default: ;
      endcase
    end
  end

  // Compare channels: stage low byte, commit on high byte, flag a fresh match
  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      stage_d[ch] = stage_q[ch];
      cmp_d[ch]   = cmp_q[ch];
      if (wr_en && addr == ADDR_W'(int'(A_CMPA_LO) + 2 * ch))
        stage_d[ch] = wdata;
      if (wr_en && addr == ADDR_W'(int'(A_CMPA_HI) + 2 * ch))
        cmp_d[ch] = {wdata, stage_q[ch]};
      pulse_d[ch] = cnt_load && (cnt_d == cmp_d[ch]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      cmp_q    <= '0;
      stage_q  <= '0;
      pulse_q  <= '0;
      run_q    <= 1'b0;
      ext_q    <= 1'b0;
    end else begin
      if (shadow_en) shadow_q <= shadow_d;
      if (ctrl_we) begin
        run_q <= wdata[0];
        ext_q <= wdata[1];
      end
      stage_q <= stage_d;
      cmp_q   <= cmp_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    case (sel)
      A_CNT_LO:  rd_data = cnt_q[DATA_W-1:0];
      A_CAPA_LO: rd_data = cap_q[0][DATA_W-1:0];
      A_CAPB_LO: rd_data = cap_q[1][DATA_W-1:0];
      A_CNT_HI, A_CAPA_HI, A_CAPB_HI: rd_data = shadow_q;
      A_CMPA_LO: rd_data = cmp_q[0][DATA_W-1:0];
      A_CMPA_HI: rd_data = cmp_q[0][CNT_W-1:DATA_W];
      A_CMPB_LO: rd_data = cmp_q[1][DATA_W-1:0];
      A_CMPB_HI: rd_data = cmp_q[1][CNT_W-1:DATA_W];
      A_CTRL:    rd_data = DATA_W'({ext_q, run_q});
      default:   rd_data = '0;
    endcase
  end

  assign run       = run_q;
  assign ext_sel   = ext_q;
  assign cmp_pulse = pulse_q;

  // R2: count low read latches live high byte
  a_r2_shadow_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == A_CNT_LO) |=> shadow_q == $past(cnt_q[CNT_W-1:DATA_W]));

  // R3: high read never returns the live high byte path
  a_r3_hi_from_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == A_CNT_HI) |=> shadow_q == $past(shadow_q));

  // R9: a compare pulse only while the count equals the compare value
  a_r9_match_a: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q[0] |-> cnt_q == cmp_q[0]);
  a_r9_match_b: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q[1] |-> cnt_q == cmp_q[1]);

  // R10: staging the low byte does not change the active compare
  a_r10_lo_staged: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == A_CMPA_LO) |=> cmp_q[0] == $past(cmp_q[0]));
endmodule

// File: rtl/tmr_coherent_top.sv
module tmr_coherent_top
  import tmr_pkg::*;
#(
  parameter  int unsigned DATA_W      = 8,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W       = 2 * DATA_W,
  localparam int unsigned NCH         = 2,
  localparam int unsigned NPIN        = NCH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              cap_a_in,
  input  logic              cap_b_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              cmp_a_out,
  output logic              cmp_b_out
);
  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  // Pin 0 = external clock, pins 1..NCH = capture triggers
  logic [NPIN-1:0] pin_raw, pin_rise;
  assign pin_raw = {cap_b_in, cap_a_in, ext_clk};

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_int_n),
      .din  (pin_raw[i]),
      .rise (pin_rise[i])
    );
  end

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_load, tick, run, ext_sel, cnt_wr_lo, cnt_wr_hi;
  logic [NCH-1:0]   cmp_pulse;
  logic [NCH-1:0][CNT_W-1:0] cap_q, cap_d;

  assign tick = run & (ext_sel ? pin_rise[0] : 1'b1);

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .wr_lo   (cnt_wr_lo),
    .wr_hi   (cnt_wr_hi),
    .wdata   (wdata),
    .cnt_q   (cnt_q),
    .cnt_d   (cnt_d),
    .cnt_load(cnt_load)
  );

  always_comb begin
    for (int ch = 0; ch < NCH; ch++)
      cap_d[ch] = pin_rise[ch+1] ? cnt_q : cap_q[ch];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cap_q <= '0;
    else            cap_q <= cap_d;
  end

  tmr_regbus #(.DATA_W(DATA_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rd_data  (rd_data),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .cnt_load (cnt_load),
    .cap_q    (cap_q),
    .run      (run),
    .ext_sel  (ext_sel),
    .cnt_wr_lo(cnt_wr_lo),
    .cnt_wr_hi(cnt_wr_hi),
    .cmp_pulse(cmp_pulse)
  );

  assign cmp_a_out = cmp_pulse[0];
  assign cmp_b_out = cmp_pulse[1];

  // R8: a capture edge copies the count of that cycle
  a_r8_capture_a: assert property (@(posedge clk) disable iff (!rst_int_n)
    pin_rise[1] |=> cap_q[0] == $past(cnt_q));

  // R8: no edge, no change
  a_r8_hold_b: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pin_rise[2] |=> cap_q[1] == $past(cap_q[1]));

  // R12: running from system clock never stalls, even during reads
  a_r12_no_stall: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run && !ext_sel && rd_en) |=> cnt_q != $past(cnt_q));
endmodule

// File: tb/tmr_coherent_top_tb.sv
module tmr_coherent_top_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0, cap_a_in = 1'b0, cap_b_in = 1'b0;
  logic [3:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic       cmp_a_out, cmp_b_out;

  int total = 0, bad = 0;
  int pa = 0, pb = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_coherent_top u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cap_a_in(cap_a_in),
    .cap_b_in(cap_b_in), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rd_data(rd_data), .cmp_a_out(cmp_a_out), .cmp_b_out(cmp_b_out)
  );

  always @(posedge clk) begin
    if (cmp_a_out) pa++;
    if (cmp_b_out) pb++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(4'h0, v[7:0]);
    wr(4'h1, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] lo_addr, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(lo_addr, lo);
    rd(lo_addr + 4'h1, hi);
    v = {hi, lo};
  endtask

  task automatic pulse_pin(input int which);
    @(negedge clk);
    if (which == 0) cap_a_in = 1'b1; else cap_b_in = 1'b1;
    repeat (3) @(negedge clk);
    if (which == 0) cap_a_in = 1'b0; else cap_b_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, e;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state on every address and both outputs
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), b);
      chk("R1 read after reset", {8'h0, b}, 16'h0);
    end
    chk("R1 cmp_a_out", {15'h0, cmp_a_out}, 16'h0);
    chk("R1 cmp_b_out", {15'h0, cmp_b_out}, 16'h0);

    // R11: byte loads while stopped, swept over every low value
    for (int i = 0; i < 256; i++) begin
      set_cnt({8'(i) ^ 8'hA5, 8'(i)});
      rd16(4'h0, v);
      chk("R11 count byte load", v, {8'(i) ^ 8'hA5, 8'(i)});
    end
    set_cnt(16'h4C21);
    wr(4'h1, 8'h9E);
    rd16(4'h0, v);
    chk("R11 high write keeps low", v, 16'h9E21);

    // R6 / R9: run for n+2 system clocks across the wrap point
    wr(4'h6, 8'h00); wr(4'h7, 8'h00);
    wr(4'h8, 8'hFB); wr(4'h9, 8'hFF);
    for (int n = 0; n < 15; n++) begin
      set_cnt(16'hFFF5);
      @(negedge clk);
      pa = 0; pb = 0;
      wr(4'hA, 8'h01);
      repeat (n) @(negedge clk);
      wr(4'hA, 8'h00);
      rd16(4'h0, v);
      e = 16'hFFF5 + 16'(n + 2);
      chk("R6 count after run with wrap", v, e);
      chk("R9 compare A pulses", 16'(pa), (n + 2 >= 11) ? 16'd1 : 16'd0);
      chk("R9 compare B pulses", 16'(pb), (n + 2 >= 6) ? 16'd1 : 16'd0);
    end

    // R2 / R3 / R12: coherent read of a running count across 0x12FF->0x1300
    set_cnt(16'h12F8);
    wr(4'hA, 8'h01);
    repeat (3) @(negedge clk);
    rd(4'h0, b);
    chk("R2 live low byte", {8'h0, b}, 16'h00FC);
    repeat (10) @(negedge clk);
    rd(4'h1, b);
    chk("R3 shadow high byte", {8'h0, b}, 16'h0012);
    rd(4'h0, b);
    rd(4'h1, b);
    chk("R12 counter kept running", {8'h0, b}, 16'h0013);
    wr(4'hA, 8'h00);

    // R4: stale shadow shared between pairs
    set_cnt(16'h3456);
    rd(4'h3, b);
    chk("R4 stale shadow on capture A high", {8'h0, b}, 16'h0013);
    rd(4'h0, b);
    rd(4'h5, b);
    chk("R4 shared shadow on capture B high", {8'h0, b}, 16'h0034);

    // R5 / R8: captures on rising edges, stopped count
    for (int k = 1; k <= 6; k++) begin
      v = 16'h1111 * 16'(k) + 16'(k);
      set_cnt(v);
      pulse_pin(0);
      set_cnt(~v);
      pulse_pin(1);
      rd16(4'h2, e);
      chk("R5 capture A value", e, v);
      rd16(4'h4, e);
      chk("R5 capture B value", e, ~v);
    end
    set_cnt(16'hA1B2);
    pulse_pin(0);
    @(negedge clk); cap_a_in = 1'b1;
    repeat (5) @(negedge clk);
    set_cnt(16'h0F0F);
    repeat (5) @(negedge clk);
    rd16(4'h2, v);
    chk("R8 held level no capture", v, 16'hA1B2);
    cap_a_in = 1'b0;
    repeat (5) @(negedge clk);
    rd16(4'h2, v);
    chk("R8 falling edge no capture", v, 16'hA1B2);

    // R7: external source counts synchronized rising edges only
    wr(4'hA, 8'h03);
    for (int n = 0; n < 7; n++) begin
      set_cnt(16'h0000);
      repeat (4) @(negedge clk);
      for (int p = 0; p < n; p++) begin
        ext_clk = 1'b1; repeat (3) @(negedge clk);
        ext_clk = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      rd16(4'h0, v);
      chk("R7 external edge count", v, 16'(n));
    end
    wr(4'hA, 8'h00);

    // R10: staged compare low byte
    wr(4'h8, 8'h77);
    rd(4'h8, b);
    chk("R10 low staged not active", {8'h0, b}, 16'h00FB);
    rd(4'h9, b);
    chk("R10 high unchanged", {8'h0, b}, 16'h00FF);
    wr(4'h9, 8'h12);
    rd(4'h8, b);
    chk("R10 low active after high write", {8'h0, b}, 16'h0077);
    rd(4'h9, b);
    chk("R10 high active", {8'h0, b}, 16'h0012);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule